// File: doc/BRIEF.md
# Dual Triangle Wave Generator

This block sits in the digital data path of a two-channel 12-bit converter. Each channel keeps a base value and its own up/down triangle counter. A trigger starts a conversion on a channel. The trigger is picked from a shared set of trigger lines by that channel's select code and gated by that channel's enable. Three clock edges later the channel's output register takes the base value plus the counter value, clamped to full scale. On the same edge the counter takes one step along its triangle. If the channel's wave mode does not select triangle generation, the output register takes the base value unchanged and the counter does not move.

Both base values are loaded by one dual write on a valid/ready port. The write can use one of three data layouts. Back-pressure rule: `wr_ready` is low while either channel has a conversion in flight, so a base value cannot change under a pending sum. A beat transfers on any rising edge where `wr_valid` and `wr_ready` are both high. A beat that carries the reserved layout code is consumed and changes nothing. The sender may hold `wr_valid` high for as long as it likes. When the two channels select the same trigger line with both enables set, one trigger updates both outputs on the same edge, each with its own amplitude.

Top module: `tri_wave_dual`

## Requirements
- R1: After reset both output registers read 0, `busy` reads 0, `wr_ready` reads 1, and both triangle counters start at 0 counting up.
- R2: A channel starts a conversion only when its enable is 1 and the trigger line indexed by its select code is high at a rising edge. With the enable at 0, or with a different line high, the channel's `busy` and output do not change.
- R3: A channel's `busy` is high for exactly three cycles after the edge that samples its trigger. Its output register changes only on the third edge after that sampling edge, which is also the edge where `busy` drops.
- R4: When wave mode bit 1 is set (code 2 or 3), the value loaded into the output is the base value plus the counter value as it stood before this conversion.
- R5: The counter advances once per completed triangle conversion, on the same edge as the output load. It counts 0,1,… up to the peak, then down to 0, and repeats. It never stays on the same value for two steps.
- R6: Amplitude code n (4 bits) sets the peak to 2^(n+1)−1. Codes 11 to 15 set the peak to 4095.
- R7: When wave mode bit 1 is clear (code 0 or 1), the output loads the base value alone and the counter keeps its value.
- R8: The base+counter sum saturates at 4095. It never wraps.
- R9: A trigger seen while the channel's `busy` is high is ignored. The conversion in flight completes once, and no extra conversion follows.
- R10: Two enabled channels that select the same line both start on one trigger and load their outputs on the same edge, each with its own amplitude code.
- R11: Dual write layouts on `wr_fmt`. Code 0: ch0 = data[11:0], ch1 = data[27:16]. Code 1: ch0 = data[15:4], ch1 = data[31:20]. Code 2: ch0 = {data[7:0],4'h0}, ch1 = {data[15:8],4'h0}. Code 3: no change.
- R12: `wr_ready` is 0 while either channel is busy. A beat offered then is not taken and leaves both base values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 8 | Shared trigger lines, sampled on each rising edge |
| ch0_trig_sel | input | 3 | Trigger line index for channel 0 |
| ch1_trig_sel | input | 3 | Trigger line index for channel 1 |
| ch0_trig_en | input | 1 | Trigger enable, channel 0 |
| ch1_trig_en | input | 1 | Trigger enable, channel 1 |
| ch0_wave | input | 2 | Wave mode for channel 0; bit 1 selects triangle |
| ch1_wave | input | 2 | Wave mode for channel 1; bit 1 selects triangle |
| ch0_amp | input | 4 | Amplitude code for channel 0 |
| ch1_amp | input | 4 | Amplitude code for channel 1 |
| wr_valid | input | 1 | Dual base write beat offered |
| wr_ready | output | 1 | Write port can take a beat |
| wr_fmt | input | 2 | Layout code of the write beat |
| wr_data | input | 32 | Write beat data |
| ch0_data | output | 12 | Channel 0 output data register |
| ch1_data | output | 12 | Channel 1 output data register |
| busy | output | 2 | Conversion in flight, bit per channel |

## Verification
The assertions assume that select codes, enables and trigger lines are stable around each rising edge. They also assume that the shared-trigger property only applies when both selects match on the sampling edge. The bench meets this by changing every input on the falling edge. It moves select, enable, wave and amplitude settings only while both channels are idle. Triggers are pulses held for one to three cycles, so the held-trigger cases stay inside the window in which the trigger must be ignored.

// File: rtl/tri_wave_pkg.sv
package tri_wave_pkg;

  typedef enum logic [1:0] {
    FMT_R12 = 2'd0,
    FMT_L12 = 2'd1,
    FMT_R8  = 2'd2,
    FMT_RSV = 2'd3
  } wr_fmt_e;

endpackage

// File: rtl/tw_trig_pick.sv
module tw_trig_pick #(
  parameter int NUM_TRIG = 8,
  localparam int SEL_W = $clog2(NUM_TRIG)
) (
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    sel,
  input  logic                en,
  input  logic                busy,
  output logic                start
);
  // A conversion in flight masks any further trigger.
  assign start = en && !busy && trig_in[sel];
endmodule

// File: rtl/tw_tri_counter.sv
module tw_tri_counter #(
  parameter int DATA_W = 12,
  parameter int AMP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [AMP_W-1:0]  amp,
  output logic [DATA_W-1:0] cnt
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [AMP_W-1:0] SAT_CODE = AMP_W'(DATA_W - 1);

  logic              up_q;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] peak;

  always_comb begin
    if (amp >= SAT_CODE) peak = '1;
    else                 peak = (ONE << (amp + 1'b1)) - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      if (up_q) begin
        if (cnt_q >= peak) begin
          up_q  <= 1'b0;
          cnt_q <= cnt_q - ONE;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          up_q  <= 1'b1;
          cnt_q <= ONE;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tw_channel.sv
module tw_channel #(
  parameter int DATA_W = 12,
  parameter int AMP_W  = 4,
  parameter int LAT    = 3,
  localparam int STG_W = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        wave,
  input  logic [AMP_W-1:0]  amp,
  input  logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] data_out,
  output logic              busy
);
  localparam logic [STG_W-1:0] LAST = STG_W'(LAT);

  logic [STG_W-1:0]  stage_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] clamped;
  logic              done;
  logic              tri_on;

  assign tri_on  = wave[1];
  assign done    = (stage_q == LAST);
  assign sum     = {1'b0, base} + {1'b0, cnt};
  assign clamped = sum[DATA_W] ? '1 : sum[DATA_W-1:0];

  tw_tri_counter #(.DATA_W(DATA_W), .AMP_W(AMP_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (done && tri_on),
    .amp   (amp),
    .cnt   (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else if (stage_q == '0) begin
      if (start) stage_q <= STG_W'(1);
    end else if (done) begin
      stage_q <= '0;
      out_q   <= tri_on ? clamped : base;
    end else begin
      stage_q <= stage_q + STG_W'(1);
    end
  end

  assign busy     = (stage_q != '0);
  assign data_out = out_q;
endmodule

// File: rtl/tw_base_regs.sv
module tw_base_regs
  import tri_wave_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NARROW_W = 8,
  localparam int HALF_W  = 16,
  localparam int PAD_W   = DATA_W - NARROW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [1:0]          fmt,
  input  logic [2*HALF_W-1:0] data,
  output logic [DATA_W-1:0]   base0,
  output logic [DATA_W-1:0]   base1
);
  wr_fmt_e           fmt_e;
  logic [HALF_W-1:0] lo, hi;
  logic [DATA_W-1:0] nxt0, nxt1;
  logic              load;

  assign fmt_e = wr_fmt_e'(fmt);
  assign lo    = data[HALF_W-1:0];
  assign hi    = data[2*HALF_W-1:HALF_W];

  always_comb begin
    load = take;
    nxt0 = base0;
    nxt1 = base1;
    unique case (fmt_e)
      FMT_R12: begin
        nxt0 = lo[DATA_W-1:0];
        nxt1 = hi[DATA_W-1:0];
      end
      FMT_L12: begin
        nxt0 = lo[HALF_W-1 -: DATA_W];
        nxt1 = hi[HALF_W-1 -: DATA_W];
      end
      FMT_R8: begin
        nxt0 = {lo[NARROW_W-1:0], {PAD_W{1'b0}}};
        nxt1 = {lo[2*NARROW_W-1:NARROW_W], {PAD_W{1'b0}}};
      end
      FMT_RSV: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base0 <= '0;
      base1 <= '0;
    end else if (load) begin
      base0 <= nxt0;
      base1 <= nxt1;
    end
  end
endmodule

// File: rtl/tri_wave_dual.sv
module tri_wave_dual #(
  parameter int NUM_TRIG = 8,
  parameter int DATA_W   = 12,
  parameter int AMP_W    = 4,
  parameter int LAT      = 3,
  localparam int SEL_W   = $clog2(NUM_TRIG),
  localparam int NCH     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [SEL_W-1:0]    ch0_trig_sel,
  input  logic [SEL_W-1:0]    ch1_trig_sel,
  input  logic                ch0_trig_en,
  input  logic                ch1_trig_en,
  input  logic [1:0]          ch0_wave,
  input  logic [1:0]          ch1_wave,
  input  logic [AMP_W-1:0]    ch0_amp,
  input  logic [AMP_W-1:0]    ch1_amp,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [1:0]          wr_fmt,
  input  logic [31:0]         wr_data,
  output logic [DATA_W-1:0]   ch0_data,
  output logic [DATA_W-1:0]   ch1_data,
  output logic [NCH-1:0]      busy
);
  logic [SEL_W-1:0]  sel_a  [NCH];
  logic              en_a   [NCH];
  logic [1:0]        wave_a [NCH];
  logic [AMP_W-1:0]  amp_a  [NCH];
  logic [DATA_W-1:0] base_a [NCH];
  logic [DATA_W-1:0] out_a  [NCH];
  logic [NCH-1:0]    busy_a;

  assign sel_a[0]  = ch0_trig_sel;  assign sel_a[1]  = ch1_trig_sel;
  assign en_a[0]   = ch0_trig_en;   assign en_a[1]   = ch1_trig_en;
  assign wave_a[0] = ch0_wave;      assign wave_a[1] = ch1_wave;
  assign amp_a[0]  = ch0_amp;       assign amp_a[1]  = ch1_amp;

  // Base values must not move under a pending sum.
  assign wr_ready = ~|busy_a;

  tw_base_regs #(.DATA_W(DATA_W)) base_i (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (wr_valid && wr_ready),
    .fmt   (wr_fmt),
    .data  (wr_data),
    .base0 (base_a[0]),
    .base1 (base_a[1])
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic start;

    tw_trig_pick #(.NUM_TRIG(NUM_TRIG)) pick_i (
      .trig_in (trig_in),
      .sel     (sel_a[c]),
      .en      (en_a[c]),
      .busy    (busy_a[c]),
      .start   (start)
    );

    tw_channel #(.DATA_W(DATA_W), .AMP_W(AMP_W), .LAT(LAT)) ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .wave     (wave_a[c]),
      .amp      (amp_a[c]),
      .base     (base_a[c]),
      .data_out (out_a[c]),
      .busy     (busy_a[c])
    );
  end

  assign ch0_data = out_a[0];
  assign ch1_data = out_a[1];
  assign busy     = busy_a;
endmodule

// File: rtl/tri_wave_dual_chk.sv
module tri_wave_dual_chk #(
  parameter int NUM_TRIG = 8,
  parameter int DATA_W   = 12,
  parameter int LAT      = 3,
  localparam int SEL_W   = $clog2(NUM_TRIG),
  localparam int RUN_W   = $clog2(LAT + 2)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TRIG-1:0] trig_in,
  input logic [SEL_W-1:0]    ch0_trig_sel,
  input logic [SEL_W-1:0]    ch1_trig_sel,
  input logic                ch0_trig_en,
  input logic                ch1_trig_en,
  input logic [DATA_W-1:0]   ch0_data,
  input logic [DATA_W-1:0]   ch1_data,
  input logic [1:0]          busy
);
  logic [SEL_W-1:0]  sel_c [2];
  logic              en_c  [2];
  logic [DATA_W-1:0] out_c [2];

  assign sel_c[0] = ch0_trig_sel; assign sel_c[1] = ch1_trig_sel;
  assign en_c[0]  = ch0_trig_en;  assign en_c[1]  = ch1_trig_en;
  assign out_c[0] = ch0_data;     assign out_c[1] = ch1_data;

  for (genvar c = 0; c < 2; c++) begin : g_chk
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
      if (!rst_n)       run_q <= '0;
      else if (busy[c]) run_q <= run_q + RUN_W'(1);
      else              run_q <= '0;
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[c]) |-> (run_q == RUN_W'(LAT)));  // R3

    AST_OUT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_c[c]) |-> $fell(busy[c]));  // R3

    AST_EN_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_c[c] && !busy[c]) |=> !busy[c]);  // R2

    AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_c[c] && !busy[c] && trig_in[sel_c[c]]) |=> busy[c]);  // R2
  end

  AST_SHARED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_trig_sel == ch1_trig_sel && ch0_trig_en && ch1_trig_en &&
     busy == 2'b00 && trig_in[ch0_trig_sel]) |=> (busy == 2'b11));  // R10

endmodule

bind tri_wave_dual tri_wave_dual_chk #(
  .NUM_TRIG (NUM_TRIG),
  .DATA_W   (DATA_W),
  .LAT      (LAT)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_in      (trig_in),
  .ch0_trig_sel (ch0_trig_sel),
  .ch1_trig_sel (ch1_trig_sel),
  .ch0_trig_en  (ch0_trig_en),
  .ch1_trig_en  (ch1_trig_en),
  .ch0_data     (ch0_data),
  .ch1_data     (ch1_data),
  .busy         (busy)
);

// File: tb/tri_wave_dual_tb_top.sv
module tri_wave_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [2:0]  ch0_trig_sel = '0, ch1_trig_sel = '0;
  logic        ch0_trig_en = 1'b0, ch1_trig_en = 1'b0;
  logic [1:0]  ch0_wave = '0, ch1_wave = '0;
  logic [3:0]  ch0_amp = '0, ch1_amp = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_fmt = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] ch0_data, ch1_data;
  logic [1:0]  busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the two channels
  int m_base [2] = '{0, 0};
  int m_cnt  [2] = '{0, 0};
  bit m_up   [2] = '{1, 1};

  always #10 clk = ~clk;

  tri_wave_dual dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .ch0_trig_sel(ch0_trig_sel), .ch1_trig_sel(ch1_trig_sel),
    .ch0_trig_en(ch0_trig_en), .ch1_trig_en(ch1_trig_en),
    .ch0_wave(ch0_wave), .ch1_wave(ch1_wave),
    .ch0_amp(ch0_amp), .ch1_amp(ch1_amp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_fmt(wr_fmt),
    .wr_data(wr_data), .ch0_data(ch0_data), .ch1_data(ch1_data),
    .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outv(input int c);
    return (c == 0) ? int'(ch0_data) : int'(ch1_data);
  endfunction

  function automatic int peak_of(input int a);
    return (a >= 11) ? 4095 : (1 << (a + 1)) - 1;
  endfunction

  function automatic bit tri_mode(input int c);
    return (c == 0) ? ch0_wave[1] : ch1_wave[1];
  endfunction

  function automatic int exp_out(input int c);
    int s;
    if (!tri_mode(c)) return m_base[c];
    s = m_base[c] + m_cnt[c];
    return (s > 4095) ? 4095 : s;
  endfunction

  function automatic void advance(input int c);
    int pk;
    pk = peak_of((c == 0) ? int'(ch0_amp) : int'(ch1_amp));
    if (m_up[c]) begin
      if (m_cnt[c] >= pk) begin m_up[c] = 0; m_cnt[c]--; end
      else m_cnt[c]++;
    end else begin
      if (m_cnt[c] == 0) begin m_up[c] = 1; m_cnt[c]++; end
      else m_cnt[c]--;
    end
  endfunction

  // Trigger pulse held for 'hold' cycles; optional write attempt while busy.
  task automatic fire(input logic [7:0] lines, input int hold, input bit try_wr,
                      input string req);
    bit will [2];
    int expv [2];
    int old  [2];
    will[0] = ch0_trig_en && lines[ch0_trig_sel];
    will[1] = ch1_trig_en && lines[ch1_trig_sel];
    for (int c = 0; c < 2; c++) begin
      old[c]  = outv(c);
      expv[c] = will[c] ? exp_out(c) : old[c];
    end
    @(negedge clk) trig_in = lines;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == hold) trig_in = '0;
      if (k == 1) begin
        for (int c = 0; c < 2; c++) check({req, " R2 busy start"}, int'(busy[c]), int'(will[c]));
        check({req, " R12 ready"}, int'(wr_ready), int'(!(will[0] || will[1])));
        if (try_wr) begin
          wr_valid = 1'b1; wr_fmt = 2'd0; wr_data = 32'h0777_0555;
        end
      end
      if (k == 2) wr_valid = 1'b0;
      if (k == 3)
        for (int c = 0; c < 2; c++) check({req, " R3 hold"}, outv(c), old[c]);
    end
    for (int c = 0; c < 2; c++) begin
      check({req, " R3 load"}, outv(c), expv[c]);
      check({req, " R3 busy end"}, int'(busy[c]), 0);
      if (will[c] && tri_mode(c)) advance(c);
    end
  endtask

  task automatic wr_base(input logic [1:0] fmt, input logic [31:0] d);
    @(negedge clk);
    check("R12 ready idle", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_fmt = fmt; wr_data = d;
    @(negedge clk) wr_valid = 1'b0;
    case (fmt) // R11 layouts
      2'd0: begin m_base[0] = int'(d[11:0]);  m_base[1] = int'(d[27:16]); end
      2'd1: begin m_base[0] = int'(d[15:4]);  m_base[1] = int'(d[31:20]); end
      2'd2: begin m_base[0] = int'(d[7:0]) * 16; m_base[1] = int'(d[15:8]) * 16; end
      default: ;
    endcase
  endtask

  task automatic t_reset;
    check("R1 ch0", int'(ch0_data), 0);
    check("R1 ch1", int'(ch1_data), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(wr_ready), 1);
  endtask

  task automatic t_formats;
    ch0_trig_sel = 3'd1; ch1_trig_sel = 3'd1;
    ch0_trig_en = 1; ch1_trig_en = 1; ch0_wave = 2'b01; ch1_wave = 2'b00;
    wr_base(2'd0, 32'h0ABC_0123); fire(8'h02, 1, 0, "R11 fmt0 R7 R10");
    check("R11 fmt0 ch0", int'(ch0_data), 'h123);
    check("R11 fmt0 ch1", int'(ch1_data), 'hABC);
    wr_base(2'd1, 32'hABC0_1230); fire(8'h02, 1, 0, "R11 fmt1");
    wr_base(2'd2, 32'h0000_5A3C); fire(8'h02, 1, 0, "R11 fmt2");
    check("R11 fmt2 ch0", int'(ch0_data), 'h3C0);
    check("R11 fmt2 ch1", int'(ch1_data), 'h5A0);
    wr_base(2'd3, 32'h1234_5678); fire(8'h02, 1, 0, "R11 fmt3 ignored");
    check("R11 fmt3 ch0", int'(ch0_data), 'h3C0);
  endtask

  task automatic t_triangle;
    wr_base(2'd0, 32'h0100_0100);
    ch0_wave = 2'b10; ch1_wave = 2'b11; ch0_amp = 4'd1; ch1_amp = 4'd0;
    // counter untouched by the earlier base-only conversions (R7)
    fire(8'h02, 1, 0, "R7 R4 first");
    check("R7 first ch0", int'(ch0_data), 'h100);
    for (int i = 0; i < 12; i++) fire(8'h02, 1, 0, "R4 R5 R6 R10 tri");
  endtask

  task automatic t_sat;
    wr_base(2'd0, 32'h0FFF_0FF8);
    ch0_amp = 4'd3;
    for (int i = 0; i < 20; i++) fire(8'h02, 1, 0, "R8 sat");
  endtask

  task automatic t_retrig;
    fire(8'h02, 3, 0, "R9 held trig");
    repeat (4) @(negedge clk);
    check("R9 no second conv", int'(busy), 0);
    fire(8'h02, 2, 0, "R9 after");
  endtask

  task automatic t_enable;
    ch0_trig_en = 0;
    fire(8'h02, 1, 0, "R2 en off");
    ch0_trig_en = 1; ch0_trig_sel = 3'd2; ch1_trig_sel = 3'd5;
    fire(8'h20, 1, 0, "R2 line5");
    fire(8'h04, 1, 0, "R2 line2");
    fire(8'h01, 1, 0, "R2 other line");
    ch1_trig_sel = 3'd2;
  endtask

  task automatic t_busy_write;
    ch0_wave = 2'b00; ch1_wave = 2'b00;
    fire(8'h04, 1, 1, "R12 write while busy");
    fire(8'h04, 1, 0, "R12 base kept");
  endtask

  task automatic t_big_amp;
    wr_base(2'd0, 32'h0000_0000);
    ch0_wave = 2'b10; ch1_wave = 2'b10; ch0_amp = 4'd11; ch1_amp = 4'd12;
    for (int i = 0; i < 4200; i++) fire(8'h04, 1, 0, "R6 R5 full peak");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_triangle();
    t_sat();
    t_retrig();
    t_enable();
    t_busy_write();
    t_big_amp();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule